// File: doc/BRIEF.md
# Horizontal Sync and Clamp Pulse Generator

This block keeps the line timing for a video sync processor. It runs on a fine clock. A line is made of two half-line periods, so the line timebase steps at twice the line rate. From the current position in the line it makes two registered pulses. The horizontal output pulse begins at the first edge of the line. The back-porch clamp pulse follows at a fixed delay. All widths and offsets are counted in fine-clock cycles, and the default values assume a 27 MHz clock.

A phase-locked loop sends a one-cycle line-start strobe when it sees the leading edge of an incoming line sync. A flag from the loop says whether sync is present. A strobe is honoured only while that flag is high, and it starts a new line at once. When no strobe arrives, the timebase wraps by itself at the nominal line length. Both pulses therefore continue when no input signal is present.

Top module: `hsync_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `hout` and `clamp` are low after that edge. The first edge with `rst_n` high starts a fresh line, so `hout` is high after it.
- R2: A clock edge that samples `line_start` and `sync_present` both high sets the line position to 0. `hout` is high after that edge, with no added delay.
- R3: `hout` stays high for exactly HOUT_W cycles from the start of a line (146 by default). It is low at position HOUT_W.
- R4: `clamp` first goes high at line position CLAMP_DLY (146 by default), counted from the edge where `hout` rose. `hout` and `clamp` are never high together.
- R5: `clamp` stays high for exactly CLAMP_W cycles (92 by default). It is low at position CLAMP_DLY+CLAMP_W.
- R6: With no qualified strobe, the line position wraps after 2*HALF_LEN cycles (1716 by default) and `hout` rises again. This free-running repeats indefinitely, and it continues with `sync_present` low.
- R7: A `line_start` pulse sampled while `sync_present` is low has no effect. The position keeps counting, `hout` stays low at the next edge, and the next wrap comes at the normal time.
- R8: A qualified strobe in the middle of a line restarts the line at once. This holds even while `hout` is already high. The pulse then runs its full width from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine clock (27 MHz by default) |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle strobe from the PLL at the sync leading edge |
| sync_present | input | 1 | High while input sync is detected; qualifies `line_start` |
| hout | output | 1 | Registered horizontal output pulse |
| clamp | output | 1 | Registered back-porch clamp (burst-key) pulse |

## Verification
The assertions check the following on every cycle:
- the timebase advances by one or wraps exactly at the line end;
- every qualified strobe restarts the position at zero and raises `hout` on that edge;
- the two pulses never overlap;
- reset forces both outputs low.

The bench scenarios show the pulse widths and the clamp offset as cycle counts on the ports. They also show that strobes are ignored while sync is absent, that a restart during a pulse stretches it, and that the line period holds during free-running. A behavioural model of the line position is compared with both outputs on every clock.

// File: rtl/hsync_pkg.sv
// Package: shared helpers for the horizontal pulse generator.
// Assumes integer clock rates in kHz/Hz and times in ns; results round to nearest.
package hsync_pkg;

    // Convert a duration in ns to fine-clock cycles, rounded to nearest.
    function automatic int unsigned ns_to_cyc(input int unsigned clk_khz,
                                              input int unsigned ns);
        return (clk_khz * ns + 32'd500000) / 32'd1000000;
    endfunction

    // Cycles per half line (timebase runs at twice the line rate), rounded.
    function automatic int unsigned half_line_cyc(input int unsigned clk_hz,
                                                  input int unsigned line_hz);
        return (clk_hz + line_hz) / (2 * line_hz);
    endfunction

endpackage

// File: rtl/hsync_timebase.sv
// Module: hsync_timebase
// Line position counter made of a fine half-line counter and a half-line
// phase bit. A restart forces position 0; otherwise the position advances
// by one and wraps after two half lines. Exposes both the registered and the
// next position so downstream pulses can be registered without extra delay.
// Assumes HALF_LEN >= 2. Reset loads the last position so the first edge after
// reset begins a fresh line.
module hsync_timebase #(
    parameter int unsigned HALF_LEN = 858,
    localparam int unsigned FW = $clog2(HALF_LEN),
    localparam int unsigned PW = $clog2(2 * HALF_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [PW-1:0] pos_nxt,
    output logic [PW-1:0] pos
);

    localparam logic [FW-1:0] FINE_LAST = FW'(HALF_LEN - 1);
    localparam logic [PW-1:0] HALF_OFS  = PW'(HALF_LEN);
    localparam logic [PW-1:0] POS_LAST  = PW'(2 * HALF_LEN - 1);

    logic [FW-1:0] fine_q, fine_d;
    logic          half_q, half_d;

    // Next-state of the half-line counter and phase bit.
    always_comb begin
        if (restart) begin
            fine_d = '0;
            half_d = 1'b0;
        end else if (fine_q == FINE_LAST) begin
            fine_d = '0;
            half_d = ~half_q;
        end else begin
            fine_d = fine_q + 1'b1;
            half_d = half_q;
        end
    end

    // State registers; reset parks the counter on the final position of a line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_q <= FINE_LAST;
            half_q <= 1'b1;
        end else begin
            fine_q <= fine_d;
            half_q <= half_d;
        end
    end

    // Combine phase and fine count into a line position.
    always_comb begin
        pos     = PW'(fine_q) + (half_q ? HALF_OFS : '0);
        pos_nxt = PW'(fine_d) + (half_d ? HALF_OFS : '0);
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pos == '0)); // R8

    AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && pos == POS_LAST) |=> (pos == '0)); // R6

    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && pos != POS_LAST) |=> (pos == PW'($past(pos) + 1'b1))); // R6

endmodule

// File: rtl/hsync_window.sv
// Module: hsync_window
// Registered pulse that is high while the next line position lies in
// [START, START+WIDTH). Decoding the next position makes the output change on
// the same edge as the position. Assumes START+WIDTH <= 2^PW and WIDTH >= 1.
module hsync_window #(
    parameter int unsigned PW    = 11,
    parameter int unsigned START = 0,
    parameter int unsigned WIDTH = 146
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pos_nxt,
    output logic          pulse
);

    localparam logic [PW:0] LO = (PW+1)'(START);
    localparam logic [PW:0] HI = (PW+1)'(START + WIDTH);

    logic in_win;

    // Window decode; a window starting at zero needs only its upper bound.
    generate
        if (START == 0) begin : g_from_zero
            always_comb in_win = ({1'b0, pos_nxt} < HI);
        end else begin : g_offset
            always_comb in_win = ({1'b0, pos_nxt} >= LO) && ({1'b0, pos_nxt} < HI);
        end
    endgenerate

    // Output register, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= in_win;
    end

endmodule

// File: rtl/hsync_pulse_gen.sv
// Module: hsync_pulse_gen (top)
// Horizontal output and back-porch clamp pulse generator. A line-start strobe,
// qualified by the sync-present flag, restarts the line timebase; without it
// the timebase free-runs at the nominal line length. Both outputs are
// registered. Assumes HOUT_W <= CLAMP_DLY and CLAMP_DLY+CLAMP_W <= 2*HALF_LEN.
module hsync_pulse_gen #(
    parameter int unsigned HALF_LEN  = hsync_pkg::half_line_cyc(27000000, 15734),
    parameter int unsigned HOUT_W    = hsync_pkg::ns_to_cyc(27000, 5400),
    parameter int unsigned CLAMP_DLY = hsync_pkg::ns_to_cyc(27000, 5400),
    parameter int unsigned CLAMP_W   = hsync_pkg::ns_to_cyc(27000, 3400)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic sync_present,
    output logic hout,
    output logic clamp
);

    localparam int unsigned PW = $clog2(2 * HALF_LEN);

    logic          restart;
    logic [PW-1:0] pos_nxt;
    logic [PW-1:0] pos;

    // Accept a line start only while sync is detected.
    always_comb restart = line_start & sync_present;

    hsync_timebase #(.HALF_LEN(HALF_LEN)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .pos_nxt (pos_nxt),
        .pos     (pos)
    );

    hsync_window #(.PW(PW), .START(0), .WIDTH(HOUT_W)) u_hout_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_nxt (pos_nxt),
        .pulse   (hout)
    );

    hsync_window #(.PW(PW), .START(CLAMP_DLY), .WIDTH(CLAMP_W)) u_clamp_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_nxt (pos_nxt),
        .pulse   (clamp)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!hout && !clamp)); // R1

    AST_HOUT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && sync_present) |=> hout); // R2

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hout && clamp)); // R4

    AST_HOUT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) |-> hout); // R2

endmodule

// File: tb/hsync_pulse_gen_tb_top.sv
// Bench: behavioural line-position model compared on every clock, plus
// directed scenarios that measure pulse edges at the ports.
module hsync_pulse_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LINE = 1716;
    localparam int HW   = 146;
    localparam int CD   = 146;
    localparam int CW   = 92;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic sync_present = 1'b0;
    logic hout, clamp;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    hsync_pulse_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start   (line_start),
        .sync_present (sync_present),
        .hout         (hout),
        .clamp        (clamp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check result.
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural model of the line position and expected outputs.
    int  mpos = LINE - 1;
    bit  eh = 1'b0, ec = 1'b0;
    bit  started = 1'b0;
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            mpos = LINE - 1;
            eh = 1'b0;
            ec = 1'b0;
        end else begin
            if (line_start && sync_present) mpos = 0;
            else mpos = (mpos + 1) % LINE;
            eh = (mpos < HW);
            ec = (mpos >= CD) && (mpos < CD + CW);
        end
    end

    // Compare both outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk(hout === eh, "R3", "model hout", int'(hout), int'(eh));
            chk(clamp === ec, "R5", "model clamp", int'(clamp), int'(ec));
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    // One-cycle strobe; returns at the negedge after the sampling edge.
    task automatic strobe();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // Walk one full line from position 0 and check pulse edges.
    task automatic line_scan();
        for (int n = 0; n <= LINE; n++) begin
            if (n > 0) @(negedge clk);
            if (n == 0)        chk(hout === 1'b1, "R2", "hout at line start", int'(hout), 1);
            if (n == HW - 1)   chk(hout === 1'b1, "R3", "hout last cycle", int'(hout), 1);
            if (n == HW)       chk(hout === 1'b0, "R3", "hout after width", int'(hout), 0);
            if (n == CD - 1)   chk(clamp === 1'b0, "R4", "clamp before delay", int'(clamp), 0);
            if (n == CD)       chk(clamp === 1'b1, "R4", "clamp at delay", int'(clamp), 1);
            if (n == CD+CW-1)  chk(clamp === 1'b1, "R5", "clamp last cycle", int'(clamp), 1);
            if (n == CD+CW)    chk(clamp === 1'b0, "R5", "clamp after width", int'(clamp), 0);
            if (n == LINE - 1) chk(hout === 1'b0, "R6", "hout before wrap", int'(hout), 0);
            if (n == LINE)     chk(hout === 1'b1, "R6", "hout at wrap", int'(hout), 1);
        end
    endtask

    initial begin
        // R1: reset holds outputs low.
        step(5);
        chk(hout === 1'b0 && clamp === 1'b0, "R1", "outputs in reset",
            int'({hout, clamp}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hout === 1'b1, "R1", "fresh line after reset", int'(hout), 1);

        // R6: free-running line with no sync present.
        line_scan();

        // R8: qualified restart in mid-line, then a full measured line.
        sync_present = 1'b1;
        step(700);
        chk(hout === 1'b0, "R8", "hout low mid-line", int'(hout), 0);
        strobe();
        line_scan();

        // R7: strobe without sync present is ignored.
        sync_present = 1'b0;
        step(400);
        strobe();
        chk(hout === 1'b0, "R7", "ignored strobe hout", int'(hout), 0);
        step(LINE - 1 - 401);
        chk(hout === 1'b0, "R7", "hout before normal wrap", int'(hout), 0);
        step(1);
        chk(hout === 1'b1, "R7", "wrap at normal time", int'(hout), 1);

        // R8: restart while hout is already high stretches the pulse.
        sync_present = 1'b1;
        step(60);
        chk(hout === 1'b1, "R8", "hout high before restart", int'(hout), 1);
        strobe();
        line_scan();

        // R1: reset in the middle of the clamp pulse.
        step(CD + 10);
        chk(clamp === 1'b1, "R5", "clamp high before reset", int'(clamp), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(hout === 1'b0 && clamp === 1'b0, "R1", "outputs cleared by reset",
            int'({hout, clamp}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hout === 1'b1, "R1", "line restarts after reset", int'(hout), 1);
        step(20);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule